// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer and Refresh Scheduler

This block owns the SDR SDRAM command bus from reset until the memory is ready. It holds NOP for a power-up delay. It then issues a precharge of all banks and a configurable number of auto-refresh commands. It finishes with a mode-register load that sets a burst length of one and the configured CAS latency. After that it raises an init-done flag and gives the command bus to the main controller.

In normal operation a free-running interval timer produces one refresh demand per refresh period. The period is rounded down to whole clock cycles. Every other delay is rounded up. Demands build up in a small saturating counter, so a demand that arrives while an earlier one is still waiting is not lost. The request output stays high while any demand is outstanding.

The main controller closes its open row and then pulses the acknowledge. The scheduler takes the bus back, issues the REFRESH and keeps the bus for tRFC cycles before it releases it again.

Top module: `sdr_boot_refresh_sched`

## Requirements
- R1: While rst_ni is low, cmd_o is NOP, init_done_o and ref_req_o are low and own_bus_o is high.
- R2: cmd_o is {cs_n, ras_n, cas_n, we_n}: NOP = 0111, PRECHARGE = 0010, REFRESH = 0001, LOAD MODE = 0000. A PRECHARGE drives addr_o[10] high so that it closes all banks.
- R3: Only NOP is issued until the power-up delay has elapsed. The PRECHARGE appears in cycle ceil(100 µs / period) after reset release, which is cycle 12500 at 125 MHz.
- R4: INIT_REFS REFRESH commands (default 2) follow the PRECHARGE. The first comes tRP = ceil(20 ns / period) = 3 cycles after it, and each further one comes tRFC = ceil(70 ns / period) = 9 cycles after the previous one. Only NOP appears between commands.
- R5: LOAD MODE follows tRFC cycles after the last initial REFRESH. It drives addr_o = CAS_LAT in bits [6:4] with every other bit zero (burst length 1, sequential, programmed write burst) and ba_o = 0.
- R6: init_done_o rises 2 cycles after LOAD MODE, in the same cycle that own_bus_o falls, and stays high until reset.
- R7: The refresh interval is floor(15.625 µs / period) = 1953 cycles. ref_req_o first rises 1953 cycles after init_done_o rises, and the interval timer then expires every 1953 cycles regardless of when refreshes are serviced.
- R8: ref_req_o stays high until it is acknowledged. An ref_ack_i sampled high with ref_req_o high and own_bus_o low gives REFRESH on cmd_o in the next cycle. own_bus_o is then high for exactly tRFC cycles starting in that cycle.
- R9: Each interval expiry that finds a demand still outstanding is counted, up to 2^PEND_W-1. ref_req_o stays high until one accepted acknowledge has been given for each counted expiry.
- R10: When an interval expiry and an accepted acknowledge fall in the same cycle, the outstanding count stays unchanged: one REFRESH is issued and ref_req_o stays high.
- R11: ref_ack_i has no effect while ref_req_o is low or own_bus_o is high. No REFRESH is issued and the outstanding count is unchanged.
- R12: While own_bus_o is low, cmd_o is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller and SDRAM clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_ack_i | input | 1 | Main controller has closed its row; the scheduler may refresh |
| cmd_o | output | 4 | Command {cs_n, ras_n, cas_n, we_n} driven while the scheduler owns the bus |
| addr_o | output | ADDR_W | SDRAM address during scheduler commands |
| ba_o | output | BANK_W | Bank address during scheduler commands |
| own_bus_o | output | 1 | Scheduler is driving the command bus |
| init_done_o | output | 1 | Power-up sequence is complete |
| ref_req_o | output | 1 | At least one refresh is outstanding |

## Verification
The collision that matters here is an interval-timer expiry in the same clock edge as an accepted acknowledge. The counter then sees an increment and a decrement together. The bench leaves one demand outstanding, derives the next expiry edge from the measured 1953-cycle cadence, and raises the acknowledge so that it is sampled on exactly that edge. The result is correct only if a REFRESH appears, ref_req_o is still high after it, and exactly one further acknowledge clears the request.

// File: rtl/sdr_sched_pkg.sv
package sdr_sched_pkg;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  function automatic int cyc_up(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int cyc_down(input int ps, input int clk_ps);
    return ps / clk_ps;
  endfunction

  // wait counters load (n - 2), so every gap needs at least 2 cycles
  function automatic int at_least2(input int n);
    return (n < 2) ? 2 : n;
  endfunction

endpackage

// File: rtl/sdr_refi_timer.sv
module sdr_refi_timer #(
  parameter int REFI_C = 1953
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = $clog2(REFI_C + 1);
  localparam logic [W-1:0] LOAD = W'(REFI_C - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= LOAD;
    else if (!en_i || tick_o)    cnt_q <= LOAD;
    else                         cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sdr_pend_count.sv
module sdr_pend_count #(
  parameter int PEND_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic pend_o
);
  localparam logic [PEND_W-1:0] MAXV = '1;

  logic [PEND_W-1:0] cnt_q;

  assign pend_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sdr_boot_fsm.sv
module sdr_boot_fsm
  import sdr_sched_pkg::*;
#(
  parameter int PWR_C     = 12500,
  parameter int TRP_C     = 3,
  parameter int TRFC_C    = 9,
  parameter int TMRD_C    = 2,
  parameter int INIT_REFS = 2,
  parameter int CAS_LAT   = 3,
  parameter int ADDR_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              run_o,
  output logic              own_o
);
  localparam int MAXD  = (PWR_C > TRFC_C) ? PWR_C : TRFC_C;
  localparam int CW    = $clog2(MAXD + 1);
  localparam int NW    = $clog2(INIT_REFS + 1);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(CAS_LAT << 4);

  typedef enum logic [3:0] {
    ST_PWR, ST_PRE, ST_TRP, ST_REF, ST_RFC,
    ST_MRS, ST_MRD, ST_RUN, ST_RREF, ST_RRFC
  } st_e;

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic [NW-1:0] nref_q;
  logic          zero;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PWR;
      cnt_q  <= CW'(PWR_C - 1);
      nref_q <= '0;
    end else begin
      unique case (st_q)
        ST_PWR:  if (zero) st_q <= ST_PRE; else cnt_q <= cnt_q - 1'b1;
        ST_PRE:  begin st_q <= ST_TRP; cnt_q <= CW'(TRP_C - 2); end
        ST_TRP:  if (zero) st_q <= ST_REF; else cnt_q <= cnt_q - 1'b1;
        ST_REF:  begin
          st_q   <= ST_RFC;
          cnt_q  <= CW'(TRFC_C - 2);
          nref_q <= nref_q + 1'b1;
        end
        ST_RFC:  if (zero) st_q <= (nref_q == NW'(INIT_REFS)) ? ST_MRS : ST_REF;
                 else cnt_q <= cnt_q - 1'b1;
        ST_MRS:  begin st_q <= ST_MRD; cnt_q <= CW'(TMRD_C - 2); end
        ST_MRD:  if (zero) st_q <= ST_RUN; else cnt_q <= cnt_q - 1'b1;
        ST_RUN:  if (go_i) st_q <= ST_RREF;
        ST_RREF: begin st_q <= ST_RRFC; cnt_q <= CW'(TRFC_C - 2); end
        ST_RRFC: if (zero) st_q <= ST_RUN; else cnt_q <= cnt_q - 1'b1;
        default: st_q <= ST_PWR;
      endcase
    end
  end

  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    unique case (st_q)
      ST_PRE:          begin cmd_o = CMD_PRE; addr_o[10] = 1'b1; end
      ST_REF, ST_RREF: cmd_o = CMD_REF;
      ST_MRS:          begin cmd_o = CMD_LMR; addr_o = MODE_WORD; end
      default:         ;
    endcase
  end

  assign run_o = (st_q == ST_RUN) || (st_q == ST_RREF) || (st_q == ST_RRFC);
  assign own_o = (st_q != ST_RUN);
endmodule

// File: rtl/sdr_boot_refresh_sched.sv
module sdr_boot_refresh_sched
  import sdr_sched_pkg::*;
#(
  parameter int CLK_PS    = 8000,
  parameter int PWRUP_NS  = 100000,
  parameter int REFI_NS   = 15625,
  parameter int TRFC_NS   = 70,
  parameter int TRP_NS    = 20,
  parameter int TMRD_CYC  = 2,
  parameter int INIT_REFS = 2,
  parameter int CAS_LAT   = 3,
  parameter int ADDR_W    = 12,
  parameter int BANK_W    = 2,
  parameter int PEND_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_ack_i,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] ba_o,
  output logic              own_bus_o,
  output logic              init_done_o,
  output logic              ref_req_o
);
  localparam int PWR_C  = cyc_up(PWRUP_NS * 1000, CLK_PS);
  localparam int TRP_C  = at_least2(cyc_up(TRP_NS * 1000, CLK_PS));
  localparam int TRFC_C = at_least2(cyc_up(TRFC_NS * 1000, CLK_PS));
  localparam int TMRD_C = at_least2(TMRD_CYC);
  localparam int REFI_C = cyc_down(REFI_NS * 1000, CLK_PS);

  logic tick, grant;

  assign grant = ref_ack_i && ref_req_o && !own_bus_o;
  assign ba_o  = '0;

  sdr_refi_timer #(.REFI_C(REFI_C)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_done_o),
    .tick_o (tick)
  );

  sdr_pend_count #(.PEND_W(PEND_W)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .dec_i  (grant),
    .pend_o (ref_req_o)
  );

  sdr_boot_fsm #(
    .PWR_C(PWR_C), .TRP_C(TRP_C), .TRFC_C(TRFC_C), .TMRD_C(TMRD_C),
    .INIT_REFS(INIT_REFS), .CAS_LAT(CAS_LAT), .ADDR_W(ADDR_W)
  ) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (grant),
    .cmd_o  (cmd_o),
    .addr_o (addr_o),
    .run_o  (init_done_o),
    .own_o  (own_bus_o)
  );
endmodule

// File: rtl/sdr_sched_chk.sv
module sdr_sched_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_ack_i,
  input logic [3:0] cmd_o,
  input logic       own_bus_o,
  input logic       init_done_o,
  input logic       ref_req_o
);
  p_idle_nop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_bus_o |-> cmd_o == 4'b0111);

  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  p_boot_owns_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> own_bus_o);

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o && !(ref_ack_i && !own_bus_o) |=> ref_req_o);

  p_grant_ref_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o && ref_ack_i && !own_bus_o |=> cmd_o == 4'b0001 && own_bus_o);

  p_ref_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 4'b0001 |=> cmd_o == 4'b0111);

  p_no_req_boot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> !ref_req_o);

  p_ack_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o && !own_bus_o && !(ref_req_o && ref_ack_i) |=> !own_bus_o);
endmodule

bind sdr_boot_refresh_sched sdr_sched_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_ack_i   (ref_ack_i),
  .cmd_o       (cmd_o),
  .own_bus_o   (own_bus_o),
  .init_done_o (init_done_o),
  .ref_req_o   (ref_req_o)
);

// File: tb/sdr_boot_refresh_sched_bench.sv
`timescale 1ns/1ps
module sdr_boot_refresh_sched_bench;
  localparam int E_PWR  = 12500;
  localparam int E_TRP  = 3;
  localparam int E_TRFC = 9;
  localparam int E_MRD  = 2;
  localparam int E_REFI = 1953;
  localparam logic [11:0] E_MODE = 12'h030;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0, ack = 1'b0;
  logic [3:0] cmd;
  logic [11:0] addr;
  logic [1:0] ba;
  logic own, done, req;
  int cyc = 0, n_chk = 0, n_fail = 0;
  int done_cyc, last_tick;

  always #4 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  sdr_boot_refresh_sched u_sdr_boot_refresh_sched (
    .clk_i(clk), .rst_ni(rst_n), .ref_ack_i(ack), .cmd_o(cmd), .addr_o(addr),
    .ba_o(ba), .own_bus_o(own), .init_done_o(done), .ref_req_o(req)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  // one accepted acknowledge, then watch the tRFC window
  task automatic grant(input string tag);
    int e;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    e = cyc;
    chk(cmd == REF, {tag, " refresh after ack"}, cmd, REF);
    chk(own == 1'b1, {tag, " bus taken"}, own, 1);
    while (own) @(negedge clk);
    chk(cyc == e + E_TRFC, {tag, " tRFC hold"}, cyc - e, E_TRFC);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(cmd == NOP, "R1 cmd in reset", cmd, NOP);
    chk(!done && !req, "R1 flags in reset", {done, req}, 0);
    chk(own == 1'b1, "R1 own in reset", own, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_boot;
    int ec[8]; logic [3:0] ek[8]; logic [11:0] ea[8]; logic [1:0] eb[8];
    int n = 0;
    while (!done) begin
      @(negedge clk);
      if (cmd != NOP && n < 8) begin
        ec[n] = cyc; ek[n] = cmd; ea[n] = addr; eb[n] = ba; n++;
      end
    end
    done_cyc = cyc;
    chk(n == 4, "R4 command count in boot", n, 4);
    chk(ek[0] == PRE, "R2 first command precharge", ek[0], PRE);
    chk(ec[0] == E_PWR, "R3 power-up delay", ec[0], E_PWR);
    chk(ea[0][10] == 1'b1, "R2 precharge all A10", ea[0][10], 1);
    chk(ek[1] == REF && ek[2] == REF, "R4 two refreshes", {ek[1], ek[2]}, {REF, REF});
    chk(ec[1] - ec[0] == E_TRP, "R4 tRP gap", ec[1] - ec[0], E_TRP);
    chk(ec[2] - ec[1] == E_TRFC, "R4 tRFC gap", ec[2] - ec[1], E_TRFC);
    chk(ek[3] == LMR, "R5 load mode", ek[3], LMR);
    chk(ec[3] - ec[2] == E_TRFC, "R5 tRFC before mode", ec[3] - ec[2], E_TRFC);
    chk(ea[3] == E_MODE && eb[3] == 2'd0, "R5 mode word", ea[3], E_MODE);
    chk(done_cyc - ec[3] == E_MRD, "R6 init done after tMRD", done_cyc - ec[3], E_MRD);
    chk(own == 1'b0, "R6 bus released", own, 0);
  endtask

  task automatic t_interval;
    int r1, r2;
    while (!req) @(negedge clk);
    r1 = cyc;
    chk(r1 - done_cyc == E_REFI, "R7 first interval", r1 - done_cyc, E_REFI);
    grant("R8 first");
    chk(req == 1'b0, "R8 request cleared", req, 0);
    while (!req) @(negedge clk);
    r2 = cyc;
    chk(r2 - r1 == E_REFI, "R7 periodic interval", r2 - r1, E_REFI);
    grant("R8 second");
    last_tick = r2;
  endtask

  task automatic t_backlog;
    wait_cyc(last_tick + 3 * E_REFI + 5);
    chk(req == 1'b1, "R9 backlog pending", req, 1);
    ack = 1'b1;                           // held through the tRFC window
    @(negedge clk);
    chk(cmd == REF, "R9 first backlog refresh", cmd, REF);
    repeat (2) @(negedge clk);
    ack = 1'b0;
    while (own) @(negedge clk);
    chk(req == 1'b1, "R11 ack while bus owned ignored", req, 1);
    grant("R9 backlog 2");
    chk(req == 1'b1, "R9 one still outstanding", req, 1);
    grant("R9 backlog 3");
    chk(req == 1'b0, "R9 backlog drained", req, 0);
  endtask

  task automatic t_collide;
    int t4 = last_tick + 4 * E_REFI;
    wait_cyc(t4);
    chk(req == 1'b1, "R10 demand before collision", req, 1);
    wait_cyc(t4 + E_REFI - 1);
    ack = 1'b1;                           // sampled on the expiry edge
    @(negedge clk);
    ack = 1'b0;
    chk(cmd == REF, "R10 refresh on collision", cmd, REF);
    chk(req == 1'b1, "R10 count unchanged", req, 1);
    while (own) @(negedge clk);
    grant("R10 final");
    chk(req == 1'b0, "R10 cleared after one more", req, 0);
  endtask

  task automatic t_ignore;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(cmd == NOP, "R11 no refresh without request", cmd, NOP);
    chk(own == 1'b0, "R12 bus stays released", own, 0);
    @(negedge clk);
    chk(own == 1'b0 && req == 1'b0, "R11 state unchanged", {own, req}, 0);
  endtask

  initial begin
    t_reset();
    t_boot();
    t_interval();
    t_backlog();
    t_collide();
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule